// File: doc/BRIEF.md
# Integer ALU with Signed Compare

This block is the combinational arithmetic and logic unit of a simple RISC integer datapath. It takes two operands of `WIDTH` bits (32 by default) and a 4-bit operation code. It returns a result word, a flag that is high when every result bit is zero, and a signed-overflow flag. Equality branches use the zero flag after a subtraction. Signed compares use the set-on-less-than operation.

One adder does three jobs: addition, subtraction and the signed less-than test. For a subtraction it inverts operand B and feeds a carry of one into the least significant position. The overflow flag is the exclusive-or of the carry into the top bit and the carry out of it. The four bitwise operations come from a separate logic unit, and an output multiplexer chooses between that unit and the adder. Shifts, multiplication, division and immediate extension are handled elsewhere in the datapath.

Top module: `alu32_core`

## Requirements
- R1: Operation code 0010 (add) gives a result equal to A plus B, modulo 2^WIDTH.
- R2: Operation code 0110 (subtract) gives a result equal to A minus B, modulo 2^WIDTH.
- R3: For add (0010), the overflow flag is 1 exactly when A and B have the same sign bit and the result sign bit differs from it. For subtract (0110), it is 1 exactly when A and B have different sign bits and the result sign bit differs from the sign bit of A.
- R4: For operation codes 0000, 0001, 0011, 0100 and 0111, the overflow flag is 0.
- R5: The bitwise operations are 0000 for AND, 0001 for OR, 0011 for XOR and 0100 for NOR. Each gives the named bitwise function of A and B.
- R6: Operation code 0111 (set-on-less-than) gives 1 in result bit 0 when A is less than B as signed two's complement numbers, and 0 otherwise. Bits WIDTH-1..1 of the result are 0. The answer stays correct when A minus B overflows.
- R7: The zero flag is 1 exactly when every bit of the result is 0, for every operation code.
- R8: The unused operation codes 0101 and 1000 through 1111 give a result of 0, a zero flag of 1 and an overflow flag of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_i | input | 4 | Operation code |
| res_o | output | WIDTH | Result word |
| zero_o | output | 1 | High when every result bit is zero |
| ovf_o | output | 1 | Signed overflow, for add and subtract only |

## Verification
The bench goes after the operand pairs where the sign of the difference disagrees with the true ordering. Examples are 0x80000000 against 1, and 0x7FFFFFFF against 0xFFFFFFFF. A less-than that used only the difference sign would return the inverted answer there. The bench also pairs each of the four extremes with every other one under add and subtract. These pairs show up an overflow flag taken from the carry out alone, or an inverted B without its carry-in, which gives results one off. They also show up an overflow flag that leaks into the logic or compare operations. Random operands and every unused code complete the run, so a decode that falls through to the adder or the logic unit would return nonzero words.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_AND = 4'b0000,
      OP_OR  = 4'b0001,
      OP_ADD = 4'b0010,
      OP_XOR = 4'b0011,
      OP_NOR = 4'b0100,
      OP_SUB = 4'b0110,
      OP_SLT = 4'b0111
   } alu_op_e;

   typedef enum logic [1:0] {
      LG_AND = 2'd0,
      LG_OR  = 2'd1,
      LG_XOR = 2'd2,
      LG_NOR = 2'd3
   } logic_fn_e;

   typedef enum int {
      ADDER_RIPPLE = 0,
      ADDER_INFER  = 1
   } adder_kind_e;

endpackage

// File: rtl/alu32_addsub.sv
module alu32_addsub
   import alu32_pkg::*;
#(
   parameter int          WIDTH = 32,
   parameter adder_kind_e KIND  = ADDER_RIPPLE
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             c_msb_o,
   output logic             c_out_o
);

   localparam int LOW_W = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;

   assign b_eff = b_i ^ {WIDTH{sub_i}};

   generate
      if (KIND == ADDER_RIPPLE) begin : g_ripple
         logic [WIDTH:0] carry;
         assign carry[0] = sub_i;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_o[i]    = a_i[i] ^ b_eff[i] ^ carry[i];
            assign carry[i+1]  = (a_i[i] & b_eff[i]) |
                                 (a_i[i] & carry[i]) |
                                 (b_eff[i] & carry[i]);
         end
         assign c_msb_o = carry[WIDTH-1];
         assign c_out_o = carry[WIDTH];
      end else begin : g_infer
         logic [LOW_W:0] low_sum;
         logic [1:0]     top_sum;
         assign low_sum = {1'b0, a_i[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]}
                        + {{LOW_W{1'b0}}, sub_i};
         assign top_sum = {1'b0, a_i[WIDTH-1]} + {1'b0, b_eff[WIDTH-1]}
                        + {1'b0, low_sum[LOW_W]};
         assign sum_o   = {top_sum[0], low_sum[LOW_W-1:0]};
         assign c_msb_o = low_sum[LOW_W];
         assign c_out_o = top_sum[1];
      end
   endgenerate

endmodule

// File: rtl/alu32_logic.sv
module alu32_logic
   import alu32_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic_fn_e        fn_i,
   output logic [WIDTH-1:0] y_o
);

   always_comb begin
      unique case (fn_i)
         LG_AND:  y_o = a_i & b_i;
         LG_OR:   y_o = a_i | b_i;
         LG_XOR:  y_o = a_i ^ b_i;
         LG_NOR:  y_o = ~(a_i | b_i);
         default: y_o = '0;
      endcase
   end

endmodule

// File: rtl/alu32_zero.sv
module alu32_zero #(
   parameter int WIDTH = 32,
   parameter int GROUP = 8
) (
   input  logic [WIDTH-1:0] v_i,
   output logic             zero_o
);

   localparam int NG    = (WIDTH + GROUP - 1) / GROUP;
   localparam int PAD_W = NG * GROUP;

   logic [PAD_W-1:0] padded;
   logic [NG-1:0]    grp_any;

   always_comb begin
      padded              = '0;
      padded[WIDTH-1:0]   = v_i;
   end

   generate
      for (genvar g = 0; g < NG; g++) begin : g_grp
         assign grp_any[g] = |padded[g*GROUP +: GROUP];
      end
   endgenerate

   assign zero_o = ~|grp_any;

endmodule

// File: rtl/alu32_core.sv
module alu32_core
   import alu32_pkg::*;
#(
   parameter int          WIDTH      = 32,
   parameter adder_kind_e ADDER      = ADDER_RIPPLE,
   parameter int          ZERO_GROUP = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [3:0]       op_i,
   output logic [WIDTH-1:0] res_o,
   output logic             zero_o,
   output logic             ovf_o
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu32_core: WIDTH must be at least 2");
      end
      if (ZERO_GROUP < 1) begin : g_bad_group
         $error("alu32_core: ZERO_GROUP must be at least 1");
      end
   endgenerate

   alu_op_e          op;
   logic             do_sub;
   logic [WIDTH-1:0] sum;
   logic             c_msb;
   logic             c_out;
   logic             ovf_raw;
   logic             less;
   logic_fn_e        lfn;
   logic [WIDTH-1:0] lres;

   assign op     = alu_op_e'(op_i);
   assign do_sub = (op == OP_SUB) || (op == OP_SLT);

   alu32_addsub #(.WIDTH(WIDTH), .KIND(ADDER)) u_addsub (
      .a_i     (a_i),
      .b_i     (b_i),
      .sub_i   (do_sub),
      .sum_o   (sum),
      .c_msb_o (c_msb),
      .c_out_o (c_out)
   );

   assign ovf_raw = c_msb ^ c_out;
   assign less    = sum[WIDTH-1] ^ ovf_raw;

   always_comb begin
      case (op)
         OP_OR:   lfn = LG_OR;
         OP_XOR:  lfn = LG_XOR;
         OP_NOR:  lfn = LG_NOR;
         default: lfn = LG_AND;
      endcase
   end

   alu32_logic #(.WIDTH(WIDTH)) u_logic (
      .a_i  (a_i),
      .b_i  (b_i),
      .fn_i (lfn),
      .y_o  (lres)
   );

   always_comb begin
      case (op)
         OP_AND, OP_OR, OP_XOR, OP_NOR: res_o = lres;
         OP_ADD, OP_SUB:                res_o = sum;
         OP_SLT:                        res_o = {{(WIDTH-1){1'b0}}, less};
         default:                       res_o = '0;
      endcase
   end

   assign ovf_o = ((op == OP_ADD) || (op == OP_SUB)) & ovf_raw;

   alu32_zero #(.WIDTH(WIDTH), .GROUP(ZERO_GROUP)) u_zero (
      .v_i    (res_o),
      .zero_o (zero_o)
   );

endmodule

// File: rtl/alu32_core_chk.sv
module alu32_core_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic [3:0]       op_i,
   input logic [WIDTH-1:0] res_o,
   input logic             zero_o,
   input logic             ovf_o
);

   logic is_add, is_sub, is_slt, is_used;

   always_comb begin
      is_add  = (op_i == 4'b0010);
      is_sub  = (op_i == 4'b0110);
      is_slt  = (op_i == 4'b0111);
      is_used = (op_i <= 4'b0100) || is_sub || is_slt;

      AST_ZERO_MATCHES_RESULT: assert (zero_o == (res_o == '0)); // R7
      if (!is_add && !is_sub) begin
         AST_NO_OVERFLOW: assert (!ovf_o); // R4
      end
      if (is_slt) begin
         AST_SLT_UPPER_CLEAR: assert (res_o[WIDTH-1:1] == '0); // R6
      end
      if (!is_used) begin
         AST_UNUSED_ZERO: assert (res_o == '0 && zero_o); // R8
      end
      if (is_add && (a_i[WIDTH-1] == b_i[WIDTH-1])) begin
         AST_ADD_OVF_SIGN: assert (ovf_o == (res_o[WIDTH-1] != a_i[WIDTH-1])); // R3
      end
      if (is_add && (a_i[WIDTH-1] != b_i[WIDTH-1])) begin
         AST_ADD_MIXED_NO_OVF: assert (!ovf_o); // R3
      end
   end

endmodule

bind alu32_core alu32_core_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/alu32_core_tb_top.sv
module alu32_core_tb_top;

   localparam int W = 32;

   typedef struct {
      logic [3:0]   op;
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic [W-1:0] res;
      logic         z;
      logic         v;
      string        rtag;
      string        vtag;
   } item_t;

   logic         clk;
   logic         rst_n;
   logic [W-1:0] a, b;
   logic [3:0]   op;
   logic [W-1:0] res;
   logic         zero, ovf;

   int    checks;
   int    failures;
   bit    done;
   item_t sb_q[$];

   alu32_core dut_i (
      .a_i    (a),
      .b_i    (b),
      .op_i   (op),
      .res_o  (res),
      .zero_o (zero),
      .ovf_o  (ovf)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   function automatic item_t predict(logic [3:0] o, logic [W-1:0] x, logic [W-1:0] y);
      item_t it;
      it.op = o; it.a = x; it.b = y; it.v = 1'b0; it.res = '0;
      it.vtag = "R4";
      case (o)
         4'b0000: begin it.res = x & y;    it.rtag = "R5"; end
         4'b0001: begin it.res = x | y;    it.rtag = "R5"; end
         4'b0011: begin it.res = x ^ y;    it.rtag = "R5"; end
         4'b0100: begin it.res = ~(x | y); it.rtag = "R5"; end
         4'b0010: begin
            it.res = x + y; it.rtag = "R1"; it.vtag = "R3";
            it.v = (x[W-1] == y[W-1]) && (it.res[W-1] != x[W-1]);
         end
         4'b0110: begin
            it.res = x - y; it.rtag = "R2"; it.vtag = "R3";
            it.v = (x[W-1] != y[W-1]) && (it.res[W-1] != x[W-1]);
         end
         4'b0111: begin
            it.res = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0; it.rtag = "R6";
         end
         default: begin it.rtag = "R8"; it.vtag = "R8"; end
      endcase
      it.z = (it.res == '0);
      return it;
   endfunction

   task automatic drive(logic [3:0] o, logic [W-1:0] x, logic [W-1:0] y);
      @(negedge clk);
      op = o; a = x; b = y;
      sb_q.push_back(predict(o, x, y));
   endtask

   always @(posedge clk) begin
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         checks++;
         if (res !== it.res) begin
            failures++;
            $display("FAIL %s op=%b a=%h b=%h result actual %h expected %h",
                     it.rtag, it.op, it.a, it.b, res, it.res);
         end
         checks++;
         if (zero !== it.z) begin
            failures++;
            $display("FAIL R7 op=%b a=%h b=%h zero actual %b expected %b",
                     it.op, it.a, it.b, zero, it.z);
         end
         checks++;
         if (ovf !== it.v) begin
            failures++;
            $display("FAIL %s op=%b a=%h b=%h overflow actual %b expected %b",
                     it.vtag, it.op, it.a, it.b, ovf, it.v);
         end
      end
   end

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      logic [W-1:0] ext [4];
      ext[0] = 32'h7FFF_FFFF; ext[1] = 32'h8000_0000;
      ext[2] = 32'h0000_0000; ext[3] = 32'hFFFF_FFFF;
      checks = 0; failures = 0; done = 1'b0;
      a = '0; b = '0; op = 4'b0000;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset state: zero operands under AND give a zero word (R5, R7)
      drive(4'b0000, '0, '0);
      // R6 compare corners where the difference overflows
      drive(4'b0111, 32'h8000_0000, 32'h0000_0001);
      drive(4'b0111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
      drive(4'b0111, 32'hFFFF_FFFF, 32'h0000_0000);
      drive(4'b0111, 32'h0000_0005, 32'h0000_0005);
      // R3 overflow corners
      drive(4'b0010, 32'h7FFF_FFFF, 32'h0000_0001);
      drive(4'b0010, 32'h8000_0000, 32'hFFFF_FFFF);
      drive(4'b0110, 32'h8000_0000, 32'h0000_0001);
      drive(4'b0110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
      // R2 equality through subtract, R7 zero flag
      drive(4'b0110, 32'h1234_5678, 32'h1234_5678);
      // extremes on every code, including unused ones (R1..R8)
      for (int o = 0; o < 16; o++)
         for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
               drive(o[3:0], ext[i], ext[j]);
      // random operands on every code
      for (int k = 0; k < 1500; k++)
         drive($urandom_range(15, 0), $urandom, $urandom);
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      summary();
   end

endmodule